// File: doc/BRIEF.md
# Cache Interlevel Queue Link

This block joins an upper-level write-back cache to the next cache down through four bounded first-in first-out queues. Each direction gets one queue for requests and one for responses, so a queue full of requests never sits in front of a response. An upper cache that takes misses downward while it also receives snoops or write-back demands from below therefore cannot lock up against the lower cache over buffer space.

A request queue refuses a request it has no room for. The issuer sees a one-cycle negative acknowledgement in the same cycle and keeps the request to retry later, so the issuer never stalls on a full queue. Each response queue holds at least as many entries as the request bound, with optional extra slack, and uses a plain valid/ready handshake on entry. Every queue presents a valid/ready handshake at its output. Every queue also reports its occupancy count and its full and empty flags for observation.

Top module: `cache_link_queues`

## Requirements
- R1: The four queues are independent, and each delivers its entries in the order it accepted them. The status index of each queue is: 0 = upper-to-lower requests, 1 = upper-to-lower responses, 2 = lower-to-upper requests, 3 = lower-to-upper responses.
- R2: A request queue never holds more than `REQ_MAX` entries, and its full flag is high exactly when it holds `REQ_MAX`.
- R3: A request offered while its queue holds `REQ_MAX` entries is dropped, and the matching nack output is high in that same cycle. A dequeue in that cycle does not make room. The nack output is low whenever no request is offered.
- R4: A response queue holds `REQ_MAX + RSP_SLACK` entries. Its entry ready output is high whenever the queue is below that depth, whatever the state of any request queue.
- R5: An output valid is high exactly when its queue is non-empty. The head data stays unchanged until the entry is taken with ready high.
- R6: The count, full and empty outputs follow the occupancy one cycle after each handshake. A push and a pop in the same cycle leave the count unchanged.
- R7: Reset empties all four queues. After reset every count is zero, every empty flag is high, and no output valid or nack is asserted.
- R8: With both request queues full and their outputs stalled, responses still enter and leave in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Upper cache offers a request downward |
| up_req_data | input | DW | Downward request payload |
| up_req_nack | output | 1 | Downward request refused this cycle |
| up_rsp_valid | input | 1 | Upper cache offers a response downward |
| up_rsp_data | input | DW | Downward response payload |
| up_rsp_ready | output | 1 | Downward response queue has room |
| lo_req_out_valid | output | 1 | Downward request available at lower cache |
| lo_req_out_data | output | DW | Head of downward request queue |
| lo_req_out_ready | input | 1 | Lower cache takes the request |
| lo_rsp_out_valid | output | 1 | Downward response available at lower cache |
| lo_rsp_out_data | output | DW | Head of downward response queue |
| lo_rsp_out_ready | input | 1 | Lower cache takes the response |
| lo_req_valid | input | 1 | Lower cache offers a request upward |
| lo_req_data | input | DW | Upward request payload |
| lo_req_nack | output | 1 | Upward request refused this cycle |
| lo_rsp_valid | input | 1 | Lower cache offers a response upward |
| lo_rsp_data | input | DW | Upward response payload |
| lo_rsp_ready | output | 1 | Upward response queue has room |
| up_req_out_valid | output | 1 | Upward request available at upper cache |
| up_req_out_data | output | DW | Head of upward request queue |
| up_req_out_ready | input | 1 | Upper cache takes the request |
| up_rsp_out_valid | output | 1 | Upward response available at upper cache |
| up_rsp_out_data | output | DW | Head of upward response queue |
| up_rsp_out_ready | input | 1 | Upper cache takes the response |
| q_count | output | 4*CW | Occupancy of queue i in bits [i*CW +: CW] |
| q_full | output | 4 | Full flag per queue |
| q_empty | output | 4 | Empty flag per queue |

## Verification
The assertions check on every cycle that the request bound holds, that a nack never coincides with a count increase and never appears without an offer, that an accepted response raises the count when nothing leaves, and that a stalled head keeps its data. Entry order inside each queue, the exact cycle a nack appears at the bound, and the absence of blocking between queues under crossing traffic are shown only by the bench scenarios. There a behavioural model of the four queues is compared against every output each cycle while both request queues are held full.

// File: rtl/cache_link_queues.sv
module cache_link_queues #(
  parameter int DW = 32,
  parameter int REQ_MAX = 4,
  parameter int RSP_SLACK = 0,
  localparam int RSP_DEPTH = REQ_MAX + RSP_SLACK,
  localparam int PW = (RSP_DEPTH > 1) ? $clog2(RSP_DEPTH) : 1,
  localparam int CW = $clog2(RSP_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req_valid,
  input  logic [DW-1:0] up_req_data,
  output logic          up_req_nack,
  input  logic          up_rsp_valid,
  input  logic [DW-1:0] up_rsp_data,
  output logic          up_rsp_ready,
  output logic          lo_req_out_valid,
  output logic [DW-1:0] lo_req_out_data,
  input  logic          lo_req_out_ready,
  output logic          lo_rsp_out_valid,
  output logic [DW-1:0] lo_rsp_out_data,
  input  logic          lo_rsp_out_ready,
  input  logic          lo_req_valid,
  input  logic [DW-1:0] lo_req_data,
  output logic          lo_req_nack,
  input  logic          lo_rsp_valid,
  input  logic [DW-1:0] lo_rsp_data,
  output logic          lo_rsp_ready,
  output logic          up_req_out_valid,
  output logic [DW-1:0] up_req_out_data,
  input  logic          up_req_out_ready,
  output logic          up_rsp_out_valid,
  output logic [DW-1:0] up_rsp_out_data,
  input  logic          up_rsp_out_ready,
  output logic [4*CW-1:0] q_count,
  output logic [3:0]    q_full,
  output logic [3:0]    q_empty
);

  logic [3:0]    in_v, room, out_v, out_r;
  logic [DW-1:0] in_d  [4];
  logic [DW-1:0] out_d [4];

  assign in_v  = {lo_rsp_valid, lo_req_valid, up_rsp_valid, up_req_valid};
  assign out_r = {up_rsp_out_ready, up_req_out_ready, lo_rsp_out_ready, lo_req_out_ready};
  assign in_d[0] = up_req_data;
  assign in_d[1] = up_rsp_data;
  assign in_d[2] = lo_req_data;
  assign in_d[3] = lo_rsp_data;

  assign up_req_nack  = up_req_valid && !room[0];
  assign up_rsp_ready = room[1];
  assign lo_req_nack  = lo_req_valid && !room[2];
  assign lo_rsp_ready = room[3];

  assign lo_req_out_valid = out_v[0];
  assign lo_req_out_data  = out_d[0];
  assign lo_rsp_out_valid = out_v[1];
  assign lo_rsp_out_data  = out_d[1];
  assign up_req_out_valid = out_v[2];
  assign up_req_out_data  = out_d[2];
  assign up_rsp_out_valid = out_v[3];
  assign up_rsp_out_data  = out_d[3];

  for (genvar q = 0; q < 4; q++) begin : g_q
    localparam int D = (q % 2 == 0) ? REQ_MAX : RSP_DEPTH;
    logic [DW-1:0] mem [2**PW];
    logic [PW-1:0] wr, rd;
    logic [CW-1:0] n;
    logic          push, pop;

    assign room[q] = n < CW'(D);
    assign push    = in_v[q] && room[q];
    assign pop     = (n != '0) && out_r[q];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr <= '0;
        rd <= '0;
        n  <= '0;
      end else begin
        if (push) wr <= (wr == PW'(D - 1)) ? '0 : wr + 1'b1;
        if (pop)  rd <= (rd == PW'(D - 1)) ? '0 : rd + 1'b1;
        n <= n + CW'(push) - CW'(pop);
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wr] <= in_d[q];
    end

    assign out_v[q] = (n != '0);
    assign out_d[q] = mem[rd];
    assign q_count[q*CW +: CW] = n;
    assign q_full[q]  = !room[q];
    assign q_empty[q] = (n == '0);
  end

endmodule

module cache_link_queues_chk #(
  parameter int DW = 32,
  parameter int REQ_MAX = 4,
  parameter int RSP_SLACK = 0,
  localparam int RSP_DEPTH = REQ_MAX + RSP_SLACK,
  localparam int CW = $clog2(RSP_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_req_valid,
  input logic          up_req_nack,
  input logic          lo_req_valid,
  input logic          lo_req_nack,
  input logic          up_rsp_valid,
  input logic          up_rsp_ready,
  input logic          lo_rsp_valid,
  input logic          lo_rsp_ready,
  input logic          lo_req_out_valid,
  input logic [DW-1:0] lo_req_out_data,
  input logic          lo_req_out_ready,
  input logic          lo_rsp_out_valid,
  input logic          lo_rsp_out_ready,
  input logic          up_req_out_valid,
  input logic [DW-1:0] up_req_out_data,
  input logic          up_req_out_ready,
  input logic          up_rsp_out_valid,
  input logic          up_rsp_out_ready,
  input logic [4*CW-1:0] q_count,
  input logic [3:0]    q_full,
  input logic [3:0]    q_empty
);

  assert_req_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_count[0 +: CW]) <= REQ_MAX) && (int'(q_count[2*CW +: CW]) <= REQ_MAX));

  assert_dn_nack_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_nack |=> q_count[0 +: CW] <= $past(q_count[0 +: CW]));

  assert_up_nack_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req_nack |=> q_count[2*CW +: CW] <= $past(q_count[2*CW +: CW]));

  assert_nack_needs_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_nack |-> up_req_valid) and (lo_req_nack |-> lo_req_valid));

  assert_dn_rsp_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && up_rsp_ready && !(lo_rsp_out_valid && lo_rsp_out_ready))
    |=> int'(q_count[CW +: CW]) == int'($past(q_count[CW +: CW])) + 1);

  assert_up_rsp_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rsp_valid && lo_rsp_ready && !(up_rsp_out_valid && up_rsp_out_ready))
    |=> int'(q_count[3*CW +: CW]) == int'($past(q_count[3*CW +: CW])) + 1);

  assert_dn_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req_out_valid && !lo_req_out_ready) |=> lo_req_out_valid && $stable(lo_req_out_data));

  assert_up_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_out_valid && !up_req_out_ready) |=> up_req_out_valid && $stable(up_req_out_data));

  assert_empty_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty[0] |-> !lo_req_out_valid) and (q_empty[3] |-> !up_rsp_out_valid));

endmodule

bind cache_link_queues cache_link_queues_chk #(
  .DW(DW), .REQ_MAX(REQ_MAX), .RSP_SLACK(RSP_SLACK)
) i_chk (.*);

// File: tb/test_cache_link_queues.sv
module test_cache_link_queues;
  localparam int DW = 8;
  localparam int REQ_MAX = 3;
  localparam int RSP_SLACK = 2;
  localparam int CW = $clog2(REQ_MAX + RSP_SLACK + 1);

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic [3:0]    iv = '0, orr = '0;
  logic [DW-1:0] id [4];
  logic [DW-1:0] od [4];
  logic [3:0]    ov, acc_sig;
  logic [4*CW-1:0] q_count;
  logic [3:0]    q_full, q_empty;
  logic          up_req_nack, up_rsp_ready, lo_req_nack, lo_rsp_ready;

  cache_link_queues #(.DW(DW), .REQ_MAX(REQ_MAX), .RSP_SLACK(RSP_SLACK)) i_cache_link_queues (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(iv[0]), .up_req_data(id[0]), .up_req_nack(up_req_nack),
    .up_rsp_valid(iv[1]), .up_rsp_data(id[1]), .up_rsp_ready(up_rsp_ready),
    .lo_req_out_valid(ov[0]), .lo_req_out_data(od[0]), .lo_req_out_ready(orr[0]),
    .lo_rsp_out_valid(ov[1]), .lo_rsp_out_data(od[1]), .lo_rsp_out_ready(orr[1]),
    .lo_req_valid(iv[2]), .lo_req_data(id[2]), .lo_req_nack(lo_req_nack),
    .lo_rsp_valid(iv[3]), .lo_rsp_data(id[3]), .lo_rsp_ready(lo_rsp_ready),
    .up_req_out_valid(ov[2]), .up_req_out_data(od[2]), .up_req_out_ready(orr[2]),
    .up_rsp_out_valid(ov[3]), .up_rsp_out_data(od[3]), .up_rsp_out_ready(orr[3]),
    .q_count(q_count), .q_full(q_full), .q_empty(q_empty)
  );

  assign acc_sig = {lo_rsp_ready, lo_req_nack, up_rsp_ready, up_req_nack};

  int checks = 0, fails = 0;
  logic [DW-1:0] mdl [4][$];
  logic [DW-1:0] seq [4];
  int r8_flow = 0;

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic int cap(input int q);
    return (q % 2 == 0) ? REQ_MAX : REQ_MAX + RSP_SLACK;
  endfunction

  task automatic run_phase(input int cycles, input int rqv, input int rqr,
                           input int rsv, input int rsr, input bit r8);
    for (int c = 0; c < cycles; c++) begin
      bit acc [4];
      bit pop [4];
      @(negedge clk);
      for (int q = 0; q < 4; q++) begin
        int pv = (q % 2 == 0) ? rqv : rsv;
        int pr = (q % 2 == 0) ? rqr : rsr;
        iv[q]  = ($urandom_range(99) < pv);
        orr[q] = ($urandom_range(99) < pr);
        id[q]  = seq[q];
      end
      #1;
      for (int q = 0; q < 4; q++) begin
        int sz = mdl[q].size();
        acc[q] = iv[q] && (sz < cap(q));
        pop[q] = (sz > 0) && orr[q];
        if (q % 2 == 0) chk("R3", $sformatf("nack q%0d", q), int'(acc_sig[q]), int'(iv[q] && !acc[q]));
        else            chk("R4", $sformatf("ready q%0d", q), int'(acc_sig[q]), int'(sz < cap(q)));
        chk("R5", $sformatf("valid q%0d", q), int'(ov[q]), int'(sz > 0));
        if (sz > 0) chk("R1", $sformatf("head q%0d", q), int'(od[q]), int'(mdl[q][0]));
        chk("R6", $sformatf("count q%0d", q), int'(q_count[q*CW +: CW]), sz);
        chk("R2", $sformatf("full q%0d", q), int'(q_full[q]), int'(sz == cap(q)));
        chk("R6", $sformatf("empty q%0d", q), int'(q_empty[q]), int'(sz == 0));
      end
      if (r8 && mdl[0].size() == REQ_MAX && mdl[2].size() == REQ_MAX &&
          (acc[1] || pop[1]) && (acc[3] || pop[3])) r8_flow++;
      @(posedge clk);
      for (int q = 0; q < 4; q++) begin
        if (pop[q]) void'(mdl[q].pop_front());
        if (acc[q]) begin
          mdl[q].push_back(seq[q]);
          seq[q] = seq[q] + 1'b1;
        end
      end
    end
  endtask

  initial begin
    for (int q = 0; q < 4; q++) begin
      id[q] = '0;
      seq[q] = DW'(q * 64);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    iv = 4'b0101;
    #1;
    for (int q = 0; q < 4; q++) begin
      chk("R7", $sformatf("reset count q%0d", q), int'(q_count[q*CW +: CW]), 0);
      chk("R7", $sformatf("reset empty q%0d", q), int'(q_empty[q]), 1);
      chk("R7", $sformatf("reset valid q%0d", q), int'(ov[q]), 0);
    end
    chk("R7", "reset nack", int'(up_req_nack | lo_req_nack), 0);
    iv = '0;
    rst_n = 1;
    run_phase(300, 60, 70, 60, 70, 1'b0);
    run_phase(250, 90, 0, 70, 60, 1'b1);
    chk("R8", "responses moved while both request queues full", int'(r8_flow > 20), 1);
    run_phase(250, 95, 35, 95, 25, 1'b0);
    run_phase(200, 30, 100, 30, 100, 1'b0);
    run_phase(200, 100, 100, 100, 100, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule